// File: doc/BRIEF.md
# Serial Command Frame Slave

This block is the receive side of a four-wire serial link that carries fixed-length command words into a larger device. While the select line is low, each rising edge of the serial clock moves one data bit, most significant bit first, into a frame register. When the select line goes high again, a frame that held exactly the right number of bits is handed to the command decoder. The block presents the word on a parallel bus together with a strobe that is high for one system clock. A frame of any other length is dropped without a strobe.

The data output is an open-drain line, so the block only ever drives a pull-low enable. For ordinary commands the output replays the previous frame, shifted out while the next one shifts in. The stream thus leaves the block delayed by exactly one frame, and several devices can be chained on one select line. When the captured command carries one of two readback opcodes, the block loads a register value from the decoder instead. That value is shifted out during the following frame.

All serial pins are brought into the system clock domain through synchronizer flops and sampled there. The serial clock must therefore run a few times slower than the system clock.

Top module: `spi_cmd_frame`

## Requirements
- R1: After reset, `sdo_oe` is 0, `cmd_valid` is 0 and `cmd_word` is all zeros.
- R2: A frame of exactly FRAME_W bits, taken most significant bit first on serial clock rising edges, appears on `cmd_word` with a one-cycle `cmd_valid`. This happens only after `spi_cs_n` has returned high, never while the frame is still selected. Between strobes `cmd_word` holds its value.
- R3: `cmd_valid` is never high for two system clocks in a row.
- R4: A frame that ends after fewer or more than FRAME_W clock rising edges produces no strobe and leaves `cmd_word` unchanged. The next frame of the correct length is accepted normally.
- R5: During a selected frame, the line value (0 when `sdo_oe` is 1, released to 1 otherwise) just before the k-th serial clock rising edge equals bit FRAME_W-k of the previous frame. This makes the output a replay of the input delayed by FRAME_W clock pulses.
- R6: The first frame after reset replays all zeros.
- R7: A captured word whose top OP_W bits equal RB_OP_A (9) or RB_OP_B (10) causes `rd_word` to be sampled in the cycle `cmd_valid` is high. That value is shifted out, most significant bit first, in the next frame instead of the replay.
- R8: Any other opcode in the top OP_W bits, including 8 and 11, leaves the replay behaviour of R5 in force for the next frame.
- R9: Once `spi_cs_n` has been high for more than SYNC_STAGES system clocks, `sdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_sclk | input | 1 | Serial clock, data taken on its rising edge |
| spi_sdi | input | 1 | Serial data in, most significant bit first |
| rd_word | input | FRAME_W | Readback value from the decoder, sampled while `cmd_valid` is high |
| sdo_oe | output | 1 | Pull-low enable for the open-drain data output |
| cmd_valid | output | 1 | One-cycle strobe marking a new command word |
| cmd_word | output | FRAME_W | Last accepted command word |

## Verification
The bench builds the block with its defaults: 16-bit frames, a two-flop synchronizer and readback opcodes 9 and 10 in the top four bits. The serial clock has a half period of six system clocks. At that rate the synchronizer delay fits inside each half period, so every replayed bit can be checked at the master's sampling point. Short and long frames of 12 and 20 bits exercise the exact-length rule on both sides. Opcodes 8 and 11 sit next to the readback codes and expose a decode that is off by one.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    // positions of the serial pins inside the synchronized bus
    localparam int IDX_CS   = 0;
    localparam int IDX_SCLK = 1;
    localparam int IDX_SDI  = 2;
    localparam int NUM_PINS = 3;
    // number of pins that need edge detection (select and clock)
    localparam int NUM_EDGE = 2;
    // idle levels: select high, clock low, data low
    localparam logic [NUM_PINS-1:0] PIN_IDLE = 3'b001;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
    parameter int                W       = 3,
    parameter int                STAGES  = 2,
    parameter logic [W-1:0]      RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_cmd_edge.sv
module spi_cmd_edge #(
    parameter int           W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_d, prev_q;

    always_comb prev_d = level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= prev_d;
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign rise[b] = level[b] & ~prev_q[b];
        assign fall[b] = ~level[b] & prev_q[b];
    end
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_active,
    input  logic               cs_start,
    input  logic               sclk_rise,
    input  logic               sclk_fall,
    input  logic               sdi,
    input  logic               load_en,
    input  logic [FRAME_W-1:0] load_word,
    output logic               frame_ok,
    output logic [FRAME_W-1:0] shift_word,
    output logic               sdo_bit
);
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic [CNT_W-1:0]   cnt;
        logic               out;
    } shift_t;

    shift_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            st_d.sr = load_word;
        end
        if (!cs_active) begin
            st_d.out = 1'b1;
        end else if (cs_start) begin
            st_d.cnt = '0;
            st_d.out = load_en ? load_word[FRAME_W-1] : st_q.sr[FRAME_W-1];
        end else begin
            if (sclk_rise) begin
                st_d.sr = {st_q.sr[FRAME_W-2:0], sdi};
                if (st_q.cnt != CNT_OVER) st_d.cnt = st_q.cnt + 1'b1;
            end
            if (sclk_fall) begin
                st_d.out = st_q.sr[FRAME_W-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sr  <= '0;
            st_q.cnt <= '0;
            st_q.out <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_ok   = (st_q.cnt == CNT_FULL);
    assign shift_word = st_q.sr;
    assign sdo_bit    = st_q.out;
endmodule

// File: rtl/spi_cmd_frame.sv
module spi_cmd_frame
    import spi_cmd_pkg::*;
#(
    parameter int FRAME_W     = 16,
    parameter int SYNC_STAGES = 2,
    parameter int OP_W        = 4,
    parameter int RB_OP_A     = 9,
    parameter int RB_OP_B     = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_cs_n,
    input  logic               spi_sclk,
    input  logic               spi_sdi,
    input  logic [FRAME_W-1:0] rd_word,
    output logic               sdo_oe,
    output logic               cmd_valid,
    output logic [FRAME_W-1:0] cmd_word
);
    localparam logic [OP_W-1:0] OPC_A = OP_W'(RB_OP_A);
    localparam logic [OP_W-1:0] OPC_B = OP_W'(RB_OP_B);

    typedef struct packed {
        logic [FRAME_W-1:0] word;
        logic               valid;
    } cmd_t;

    logic [NUM_PINS-1:0] pins_raw, pins_s;
    logic [NUM_EDGE-1:0] pin_rise, pin_fall;
    logic                cs_active, cs_start, cs_end;
    logic                frame_ok, sdo_bit, load_en;
    logic [FRAME_W-1:0]  shift_word;
    logic [OP_W-1:0]     opcode;
    cmd_t                cmd_d, cmd_q;

    always_comb begin
        pins_raw           = '0;
        pins_raw[IDX_CS]   = spi_cs_n;
        pins_raw[IDX_SCLK] = spi_sclk;
        pins_raw[IDX_SDI]  = spi_sdi;
    end

    spi_cmd_sync #(
        .W      (NUM_PINS),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_IDLE)
    ) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .dout (pins_s)
    );

    spi_cmd_edge #(
        .W      (NUM_EDGE),
        .RST_VAL(PIN_IDLE[NUM_EDGE-1:0])
    ) i_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .level(pins_s[NUM_EDGE-1:0]),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    assign cs_active = ~pins_s[IDX_CS];
    assign cs_start  = pin_fall[IDX_CS];
    assign cs_end    = pin_rise[IDX_CS];

    assign opcode  = cmd_q.word[FRAME_W-1 -: OP_W];
    assign load_en = cmd_q.valid && (opcode == OPC_A || opcode == OPC_B);

    spi_cmd_shifter #(
        .FRAME_W(FRAME_W)
    ) i_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_active (cs_active),
        .cs_start  (cs_start),
        .sclk_rise (pin_rise[IDX_SCLK]),
        .sclk_fall (pin_fall[IDX_SCLK]),
        .sdi       (pins_s[IDX_SDI]),
        .load_en   (load_en),
        .load_word (rd_word),
        .frame_ok  (frame_ok),
        .shift_word(shift_word),
        .sdo_bit   (sdo_bit)
    );

    always_comb begin
        cmd_d       = cmd_q;
        cmd_d.valid = 1'b0;
        if (cs_end && frame_ok) begin
            cmd_d.valid = 1'b1;
            cmd_d.word  = shift_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    assign cmd_valid = cmd_q.valid;
    assign cmd_word  = cmd_q.word;
    assign sdo_oe    = cs_active & ~sdo_bit;
endmodule

// File: rtl/spi_cmd_frame_chk.sv
module spi_cmd_frame_chk #(
    parameter int FRAME_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               spi_cs_n,
    input logic               sdo_oe,
    input logic               cmd_valid,
    input logic [FRAME_W-1:0] cmd_word
);
    localparam int IDLE_LIM = SYNC_STAGES + 1;
    localparam int IDLE_W   = $clog2(IDLE_LIM + 1) + 1;

    logic [IDLE_W-1:0] idle_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            idle_cnt <= '0;
        else if (!spi_cs_n)                    idle_cnt <= '0;
        else if (idle_cnt != IDLE_W'(IDLE_LIM)) idle_cnt <= idle_cnt + 1'b1;
    end

    // R3: strobe lasts one cycle
    p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R2: word only moves together with a strobe
    p_word_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> $stable(cmd_word));

    // R2: strobe only once select is released
    p_strobe_after_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (spi_cs_n && $past(spi_cs_n)));

    // R9: line released while deselected
    p_idle_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cnt == IDLE_W'(IDLE_LIM)) |-> !sdo_oe);
endmodule

bind spi_cmd_frame spi_cmd_frame_chk #(
    .FRAME_W    (FRAME_W),
    .SYNC_STAGES(SYNC_STAGES)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_cs_n (spi_cs_n),
    .sdo_oe   (sdo_oe),
    .cmd_valid(cmd_valid),
    .cmd_word (cmd_word)
);

// File: tb/test_spi_cmd_frame.sv
module test_spi_cmd_frame;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int GAP        = 12;
    localparam int FW         = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          sclk = 1'b0;
    logic          sdi = 1'b0;
    logic [FW-1:0] rd_word = '0;
    logic          sdo_oe;
    logic          cmd_valid;
    logic [FW-1:0] cmd_word;

    int total = 0;
    int bad = 0;
    int strobes = 0;
    int cur_run = 0;
    int max_run = 0;
    logic [FW-1:0] last_word = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cmd_frame i_spi_cmd_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_cs_n (cs_n),
        .spi_sclk (sclk),
        .spi_sdi  (sdi),
        .rd_word  (rd_word),
        .sdo_oe   (sdo_oe),
        .cmd_valid(cmd_valid),
        .cmd_word (cmd_word)
    );

    always @(negedge clk) begin
        if (cmd_valid) begin
            strobes++;
            cur_run++;
            last_word = cmd_word;
            if (cur_run > max_run) max_run = cur_run;
        end else begin
            cur_run = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one frame of nbits; echo holds the line value seen before each rising edge
    task automatic xfer(input logic [31:0] data, input int nbits,
                        output logic [31:0] echo, output int early);
        int n0;
        n0   = strobes;
        echo = '0;
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi = data[nbits-1-i];
            repeat (HALF) @(negedge clk);
            echo = {echo[30:0], ~sdo_oe};
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        early = strobes - n0;
        cs_n = 1'b1;
        repeat (GAP) @(negedge clk);
        chk(sdo_oe == 1'b0, "R9 line released after deselect", 32'(sdo_oe), 32'h0);
    endtask

    task automatic frame16(input logic [FW-1:0] w, input logic [FW-1:0] exp_echo, input string req);
        logic [31:0] e;
        int early;
        int n0;
        n0 = strobes;
        xfer(32'(w), FW, e, early);
        chk(e[FW-1:0] == exp_echo, req, e, 32'(exp_echo));
        chk(early == 0, "R2 no strobe while selected", early, 0);
        chk(strobes == n0 + 1 && last_word == w, "R2 word captured", 32'(last_word), 32'(w));
    endtask

    task automatic t_reset;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(sdo_oe == 1'b0, "R1 oe after reset", 32'(sdo_oe), 0);
        chk(cmd_valid == 1'b0, "R1 strobe after reset", 32'(cmd_valid), 0);
        chk(cmd_word == '0, "R1 word after reset", 32'(cmd_word), 0);
    endtask

    task automatic t_first_frame;
        frame16(16'h1234, 16'h0000, "R6 first replay is zeros");
    endtask

    task automatic t_echo;
        frame16(16'hBEEF, 16'h1234, "R5 replay of previous frame");
        frame16(16'h3C5A, 16'hBEEF, "R5 replay of previous frame");
    endtask

    task automatic t_readback;
        rd_word = 16'hA5C3;
        frame16(16'h9001, 16'h3C5A, "R5 replay before readback");
        frame16(16'h0F0F, 16'hA5C3, "R7 readback opcode 9");
        rd_word = 16'h5A3C;
        frame16(16'hA0FF, 16'h0F0F, "R5 replay before readback");
        frame16(16'h6E6E, 16'h5A3C, "R7 readback opcode 10");
    endtask

    task automatic t_other_ops;
        frame16(16'h8123, 16'h6E6E, "R5 replay");
        frame16(16'hB456, 16'h8123, "R8 opcode 8 keeps replay");
        frame16(16'h7777, 16'hB456, "R8 opcode 11 keeps replay");
    endtask

    task automatic t_short;
        logic [31:0] e;
        int early;
        int n0;
        n0 = strobes;
        xfer(32'h0ABC, 12, e, early);
        chk(strobes == n0, "R4 short frame no strobe", strobes - n0, 0);
        chk(cmd_word == 16'h7777, "R4 short frame word kept", 32'(cmd_word), 32'h7777);
    endtask

    task automatic t_long;
        logic [31:0] e;
        int early;
        int n0;
        n0 = strobes;
        xfer(32'hFEDCB, 20, e, early);
        chk(strobes == n0, "R4 long frame no strobe", strobes - n0, 0);
        chk(cmd_word == 16'h7777, "R4 long frame word kept", 32'(cmd_word), 32'h7777);
        n0 = strobes;
        xfer(32'h4242, FW, e, early);
        chk(strobes == n0 + 1 && cmd_word == 16'h4242, "R4 recovery frame accepted",
            32'(cmd_word), 32'h4242);
    endtask

    task automatic t_pulse_width;
        chk(max_run == 1, "R3 strobe width", max_run, 1);
    endtask

    initial begin
        t_reset();
        t_first_frame();
        t_echo();
        t_readback();
        t_other_ops();
        t_short();
        t_long();
        t_pulse_width();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule